// File: doc/BRIEF.md
# Receive Link Qualifier and Lock Selector

This block is the per-channel digital monitor of a serial receiver. It picks the bit stream that feeds the clock-recovery path: one of two external serial inputs, or the channel's own transmit stream when internal loop-back is on. It watches that stream for enough transitions, and it combines the result with two validity flags from analog detectors. From these it decides whether the recovery loop may track the received data or must stay on the local reference clock.

The decision is registered. Any failing check drops the loop to the reference on the next bit clock. A return to data tracking needs sixteen consecutive clean bit clocks. A qualification enable chooses between the full three-check test and a range-only test. A local-clock input overrides every check. The link-status output is high only while the loop tracks data.

Top module: `rx_lock_qualifier`

## Requirements
- R1: With loop-back off, `rx_bit_o` equals `prim_bit_i` when `sel_prim_i` is 1 and `sec_bit_i` when `sel_prim_i` is 0.
- R2: With `loop_en_i` at 1, `rx_bit_o` equals `tx_bit_i` whatever the external inputs carry, and `tx_line_o` is 1. With loop-back off, `tx_line_o` equals `tx_bit_i`.
- R3: The density check becomes invalid once the selected stream has held one value for 60 consecutive bit clocks after its last change. Reset counts as a previous value of 0. The check becomes valid again on the bit clock after a change.
- R4: With `det_en_i` at 1, the loop tracks data only while `level_ok_i`, `range_ok_i` and the density check are all valid.
- R5: With `det_en_i` at 0, only `range_ok_i` qualifies the link. `level_ok_i` and the density check have no effect on `lock_src_o`.
- R6: While `track_en_i` is 0, the loop is held on the reference (`lock_src_o` = 0) and `link_ok_o` is 0.
- R7: On the first bit clock edge at which any enabled check fails, `lock_src_o` and `link_ok_o` drop to 0 at that edge.
- R8: `lock_src_o` rises to 1 at the 16th consecutive clock edge at which all enabled checks pass and `track_en_i` is 1, and not before.
- R9: `link_ok_o` is 1 exactly when `lock_src_o` is 1, where 1 means tracking data and 0 means locked to the reference.
- R10: An active-low asynchronous `rst_n_i` clears the run counter, the qualification counter and both registered outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| prim_bit_i | input | 1 | Sampled primary serial input |
| sec_bit_i | input | 1 | Sampled secondary serial input |
| sel_prim_i | input | 1 | 1 selects the primary input, 0 selects the secondary |
| loop_en_i | input | 1 | 1 routes the transmit stream to the receiver |
| tx_bit_i | input | 1 | Transmit serial bit |
| level_ok_i | input | 1 | Signal-level detector valid |
| range_ok_i | input | 1 | Frequency range controller valid |
| det_en_i | input | 1 | 1 enables level and density qualification |
| track_en_i | input | 1 | 0 forces the loop onto the reference clock |
| rx_bit_o | output | 1 | Bit delivered to the recovery path |
| tx_line_o | output | 1 | Bit driven to the serial output drivers |
| lock_src_o | output | 1 | 1 tracks data, 0 tracks the reference |
| link_ok_o | output | 1 | 1 link good, 0 link fault |

## Verification
A density failure can arrive at the same edge as a failure of the level or range flag. A recovery count can also be cut short by such a failure at the very edge where it would have completed. Random stimulus holds the selected bit for random runs of 40 to 80 clocks while the analog flags and the enables flip now and then. Edges where several causes fail together, or where a failure meets the 16th clean edge, therefore occur often. The bench model states density as an unbounded run length compared against 60 and predicts the registered outputs edge by edge. Every cycle is judged against that prediction, so a wrong priority or an off-by-one in either counter shows up at the exact edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Lock source encoding used on lock_src_o
  typedef enum logic {
    SRC_REF  = 1'b0,
    SRC_DATA = 1'b1
  } lock_src_e;

  // Combined qualification: full test when detectors enabled, range only otherwise
  function automatic logic checks_pass(input logic det_en,
                                       input logic level_ok,
                                       input logic range_ok,
                                       input logic dens_ok);
    if (det_en) return level_ok & range_ok & dens_ok;
    return range_ok;
  endfunction

endpackage

// File: rtl/rxq_input_mux.sv
module rxq_input_mux (
  input  logic prim_i,
  input  logic sec_i,
  input  logic sel_prim_i,
  input  logic loop_en_i,
  input  logic tx_bit_i,
  output logic rx_bit_o,
  output logic tx_line_o
);

  logic ext_bit;

  always_comb begin
    ext_bit   = sel_prim_i ? prim_i : sec_i;
    rx_bit_o  = loop_en_i ? tx_bit_i : ext_bit;
    // drivers idle at logic 1 while the stream is looped internally
    tx_line_o = loop_en_i ? 1'b1 : tx_bit_i;
  end

endmodule

// File: rtl/rxq_density_mon.sv
module rxq_density_mon #(
  parameter int RUN_LIMIT = 60,
  localparam int CW = $clog2(RUN_LIMIT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          bit_i,
  output logic          dens_ok_o,
  output logic [CW-1:0] run_o
);

  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);

  logic          prev_q;
  logic [CW-1:0] run_q;
  logic          changed;

  // Next run length: clear on a change, otherwise count up and hold at the limit
  function automatic logic [CW-1:0] run_next(input logic [CW-1:0] cur,
                                             input logic chg);
    if (chg) return '0;
    if (cur >= LIM) return LIM;
    return cur + 1'b1;
  endfunction

  assign changed = bit_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= bit_i;
      run_q  <= run_next(run_q, changed);
    end
  end

  assign dens_ok_o = (run_q != LIM);
  assign run_o     = run_q;

endmodule

// File: rtl/rxq_lock_ctrl.sv
module rxq_lock_ctrl #(
  parameter int HOLD = 16,
  localparam int QW = $clog2(HOLD + 1)
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          track_en_i,
  input  logic          det_en_i,
  input  logic          level_ok_i,
  input  logic          range_ok_i,
  input  logic          dens_ok_i,
  output logic          lock_q_o,
  output logic          fail_o,
  output logic [QW-1:0] qual_o
);

  import rxq_pkg::*;

  localparam logic [QW-1:0] LAST = QW'(HOLD - 1);

  lock_src_e     src_q;
  logic [QW-1:0] qual_q;

  assign fail_o = !track_en_i ||
                  !checks_pass(det_en_i, level_ok_i, range_ok_i, dens_ok_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      src_q  <= SRC_REF;
      qual_q <= '0;
    end else if (fail_o) begin
      src_q  <= SRC_REF;
      qual_q <= '0;
    end else if (src_q == SRC_REF) begin
      if (qual_q == LAST) begin
        src_q  <= SRC_DATA;
        qual_q <= '0;
      end else begin
        qual_q <= qual_q + 1'b1;
      end
    end
  end

  assign lock_q_o = (src_q == SRC_DATA);
  assign qual_o   = qual_q;

endmodule

// File: rtl/rx_lock_qualifier.sv
module rx_lock_qualifier #(
  parameter int RUN_LIMIT = 60,
  parameter int HOLD      = 16
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic prim_bit_i,
  input  logic sec_bit_i,
  input  logic sel_prim_i,
  input  logic loop_en_i,
  input  logic tx_bit_i,
  input  logic level_ok_i,
  input  logic range_ok_i,
  input  logic det_en_i,
  input  logic track_en_i,
  output logic rx_bit_o,
  output logic tx_line_o,
  output logic lock_src_o,
  output logic link_ok_o
);

  localparam int CW = $clog2(RUN_LIMIT + 1);
  localparam int QW = $clog2(HOLD + 1);

  // named internal events, observed by the bound checker
  logic          rx_bit_w;
  logic          dens_ok_w;
  logic [CW-1:0] run_w;
  logic          fail_w;
  logic          lock_w;
  logic [QW-1:0] qual_w;

  rxq_input_mux u_mux (
    .prim_i     (prim_bit_i),
    .sec_i      (sec_bit_i),
    .sel_prim_i (sel_prim_i),
    .loop_en_i  (loop_en_i),
    .tx_bit_i   (tx_bit_i),
    .rx_bit_o   (rx_bit_w),
    .tx_line_o  (tx_line_o)
  );

  rxq_density_mon #(.RUN_LIMIT(RUN_LIMIT)) u_dens (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .bit_i     (rx_bit_w),
    .dens_ok_o (dens_ok_w),
    .run_o     (run_w)
  );

  rxq_lock_ctrl #(.HOLD(HOLD)) u_lock (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_i),
    .track_en_i (track_en_i),
    .det_en_i   (det_en_i),
    .level_ok_i (level_ok_i),
    .range_ok_i (range_ok_i),
    .dens_ok_i  (dens_ok_w),
    .lock_q_o   (lock_w),
    .fail_o     (fail_w),
    .qual_o     (qual_w)
  );

  assign rx_bit_o   = rx_bit_w;
  assign lock_src_o = lock_w;
  assign link_ok_o  = lock_w;

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int RUN_LIMIT = 60,
  parameter int HOLD      = 16,
  localparam int CW = $clog2(RUN_LIMIT + 1),
  localparam int QW = $clog2(HOLD + 1)
) (
  input logic          clk_i,
  input logic          rst_n_i,
  input logic          prim_bit_i,
  input logic          sec_bit_i,
  input logic          sel_prim_i,
  input logic          loop_en_i,
  input logic          tx_bit_i,
  input logic          range_ok_i,
  input logic          det_en_i,
  input logic          track_en_i,
  input logic          rx_bit_o,
  input logic          tx_line_o,
  input logic          lock_src_o,
  input logic          link_ok_o,
  input logic          dens_ok,
  input logic [CW-1:0] run,
  input logic          fail,
  input logic [QW-1:0] qual
);

  p_mux_sel_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !loop_en_i |-> (rx_bit_o == (sel_prim_i ? prim_bit_i : sec_bit_i)));

  p_loop_path_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    loop_en_i |-> (rx_bit_o == tx_bit_i) && tx_line_o);

  p_run_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    run <= CW'(RUN_LIMIT));

  p_dens_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!dens_ok && det_en_i && track_en_i) |=> !lock_src_o);

  p_range_only_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!det_en_i && range_ok_i && track_en_i && lock_src_o) |=> lock_src_o);

  p_force_ref_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !track_en_i |=> !link_ok_o);

  p_fail_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    fail |=> (!lock_src_o && !link_ok_o));

  p_hold_count_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(lock_src_o) |-> ($past(qual) == QW'(HOLD - 1)));

endmodule

bind rx_lock_qualifier rxq_checker #(.RUN_LIMIT(RUN_LIMIT), .HOLD(HOLD)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .prim_bit_i (prim_bit_i),
  .sec_bit_i  (sec_bit_i),
  .sel_prim_i (sel_prim_i),
  .loop_en_i  (loop_en_i),
  .tx_bit_i   (tx_bit_i),
  .range_ok_i (range_ok_i),
  .det_en_i   (det_en_i),
  .track_en_i (track_en_i),
  .rx_bit_o   (rx_bit_o),
  .tx_line_o  (tx_line_o),
  .lock_src_o (lock_src_o),
  .link_ok_o  (link_ok_o),
  .dens_ok    (dens_ok_w),
  .run        (run_w),
  .fail       (fail_w),
  .qual       (qual_w)
);

// File: tb/rx_lock_qualifier_bench.sv
`timescale 1ns/1ps
module rx_lock_qualifier_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic prim, sec, sel, loop_en, tx, lvl, rng, den, trk;
  logic rx_bit, tx_line, lock_src, link_ok;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // bench model state
  logic m_last;
  int   m_same;
  int   m_q;
  logic m_lock;

  always #5 clk = ~clk;

  rx_lock_qualifier u_rx_lock_qualifier (
    .clk_i(clk), .rst_n_i(rst_n),
    .prim_bit_i(prim), .sec_bit_i(sec), .sel_prim_i(sel),
    .loop_en_i(loop_en), .tx_bit_i(tx),
    .level_ok_i(lvl), .range_ok_i(rng), .det_en_i(den), .track_en_i(trk),
    .rx_bit_o(rx_bit), .tx_line_o(tx_line),
    .lock_src_o(lock_src), .link_ok_o(link_ok)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_rx();
    if (loop_en) return tx;
    return sel ? prim : sec;
  endfunction

  function automatic logic exp_ok(input logic dok);
    if (!trk) return 1'b0;
    if (den) return lvl && rng && dok;
    return rng;
  endfunction

  task automatic model_reset();
    m_last = 1'b0; m_same = 0; m_q = 0; m_lock = 1'b0;
  endtask

  // Called at a falling edge with inputs already set; returns at the next falling edge.
  task automatic step(input string tag);
    logic b, ok;
    string t;
    #1;
    b = exp_rx();
    check(loop_en ? "R2" : "R1", rx_bit, b);
    check("R2", tx_line, loop_en ? 1'b1 : tx);
    ok = exp_ok(m_same < 60);
    if (!ok) begin
      m_lock = 1'b0; m_q = 0;
    end else if (!m_lock) begin
      m_q++;
      if (m_q >= 16) m_lock = 1'b1;
    end
    if (b != m_last) m_same = 0; else m_same++;
    m_last = b;
    @(negedge clk);
    if (tag != "") t = tag;
    else if (!trk) t = "R6";
    else if (!ok) t = "R7";
    else t = den ? "R4" : "R5";
    check(t, lock_src, m_lock);
    check("R9", link_ok, lock_src);
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    int hold_len, left;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    {prim, sec, sel, loop_en, tx, lvl, rng, den, trk} = '0;
    model_reset();
    @(negedge clk); @(negedge clk);
    // R10: reset state
    check("R10", lock_src, 1'b0);
    check("R10", link_ok, 1'b0);
    rst_n = 1'b1;

    // R1: input selection, loop forced to reference meanwhile
    sel = 1'b1; sec = 1'b0;
    for (int i = 0; i < 4; i++) begin prim = i[0]; step("R6"); end
    sel = 1'b0; prim = 1'b1;
    for (int i = 0; i < 4; i++) begin sec = i[0]; step("R6"); end

    // R2: loop-back ignores external inputs
    loop_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tx = i[1]; prim = $urandom_range(0, 1); sec = $urandom_range(0, 1);
      step("R6");
    end
    loop_en = 1'b0; tx = 1'b0;

    // R8: qualification after 16 clean edges
    sel = 1'b1; trk = 1'b1; den = 1'b1; lvl = 1'b1; rng = 1'b1;
    for (int i = 0; i < 20; i++) begin prim = ~prim; step("R8"); end
    check("R8", lock_src, 1'b1);

    // R3: long run without transitions drops lock, change restores density
    for (int i = 0; i < 70; i++) step("R3");
    check("R3", lock_src, 1'b0);
    for (int i = 0; i < 18; i++) begin prim = ~prim; step("R3"); end

    // R5: detectors disabled, level and density ignored
    den = 1'b0; lvl = 1'b0;
    for (int i = 0; i < 90; i++) step("R5");
    check("R5", lock_src, 1'b1);

    // R6: local clock override
    trk = 1'b0; step("R6");
    trk = 1'b1;
    for (int i = 0; i < 17; i++) step("R5");

    // R7: a single-cycle level failure with detectors on
    den = 1'b1; lvl = 1'b1;
    for (int i = 0; i < 17; i++) begin prim = ~prim; step(""); end
    lvl = 1'b0; prim = ~prim; step("R7");
    lvl = 1'b1;
    for (int i = 0; i < 3; i++) begin prim = ~prim; step("R7"); end

    // random mix
    hold_len = 0; left = 0;
    for (int i = 0; i < 4000; i++) begin
      if (left == 0) begin
        left = $urandom_range(40, 80);
        prim = ~prim; sec = ~sec; tx = ~tx;
      end
      left--;
      if ($urandom_range(0, 31) == 0) sel     = ~sel;
      if ($urandom_range(0, 63) == 0) loop_en = ~loop_en;
      if ($urandom_range(0, 23) == 0) lvl     = ~lvl;
      if ($urandom_range(0, 23) == 0) rng     = ~rng;
      if ($urandom_range(0, 47) == 0) den     = ~den;
      if ($urandom_range(0, 63) == 0) trk     = ~trk;
      if ($urandom_range(0, 15) == 0) begin lvl = 1'b1; rng = 1'b1; trk = 1'b1; end
      step("");
    end
    hold_len = left;

    // R10: asynchronous reset between edges, after reaching lock
    trk = 1'b1; den = 1'b0; rng = 1'b1; loop_en = 1'b0;
    for (int i = 0; i < 20; i++) step("R5");
    check("R10", lock_src, 1'b1);
    #2 rst_n = 1'b0;
    #1;
    check("R10", lock_src, 1'b0);
    check("R10", link_ok, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 18; i++) step("R10");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule